// File: doc/BRIEF.md
# Bi-Endian Load/Store Byte-Lane Aligner

This block sits on the data path between a 32-bit data cache or bus and the register file of a simple RISC core. On a load it takes the raw memory word and returns a byte, halfword or word result. Sub-word results are sign-extended or zero-extended. On a store it places the register data into the correct byte lanes and produces the matching byte-enable strobes.

Byte order is set by two independent mode inputs. The core-side order bit remaps sub-word byte addresses by XOR with a small constant. Word accesses are never remapped by this bit. The bus-side order bit reverses all byte lanes on every access, word accesses included, whenever it disagrees with the core-side bit. With that reversal, byte buffers keep the same memory positions under both core byte orders.

Accesses at a misaligned address are flagged and suppressed. The outputs are registered by default, which adds one cycle of latency.

Top module: `ble_lane_aligner`

## Requirements
- R1: For a byte access, the selected lane is addr XOR 3 when cpu_be=1 and addr XOR 0 when cpu_be=0. Lane i is memory bits [8i+7:8i]. A load returns that lane in result bits [7:0].
- R2: For a halfword access, the selected lane is addr XOR 2 when cpu_be=1 and addr XOR 0 when cpu_be=0. The halfword at lane L occupies bits [8L+15:8L]. A word access uses all 32 bits with no remap.
- R3: In a sub-word load, every result bit above the loaded data holds the loaded sign bit when is_signed=1, and holds 0 when is_signed=0.
- R4: When cpu_be differs from bus_be, all four byte lanes are reversed (lane i swaps with lane 3-i). On loads this happens to the memory data before extraction. On stores it happens to the positioned data and to byte_en after positioning. This applies to words as well.
- R5: A store copies the register's low byte into all four lanes for a byte access, copies the low halfword into both halves for a halfword access, and passes the word unchanged. byte_en has one bit set at the selected lane for a byte store. It has two adjacent bits starting at the selected lane for a halfword store, and all four bits for a word store. R4 is then applied to both.
- R6: During a load, byte_en and mem_wdata are zero. During a store, load_result is zero.
- R7: misalign is 1 for a halfword access with addr[0]=1, and for a word access with addr≠0. When misalign is 1, load_result, mem_wdata and byte_en are all zero.
- R8: The size encoding is 00 for byte, 01 for halfword and 10 for word. Code 11 behaves as word.
- R9: The outputs are registered. They reflect the inputs present at the previous rising clock edge, and they are zero while rst_n is low.
- R10: A word stored and then loaded back under a mode pair with the same cpu_be/bus_be disagreement returns the identical value. With bus_be held fixed, a byte stored at a given address lands in the same memory lane whatever cpu_be is, so it can be read back under the other cpu_be.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Byte offset within the word |
| size | input | 2 | Access size code |
| is_signed | input | 1 | Sign-extend sub-word loads |
| is_store | input | 1 | 1 for store, 0 for load |
| cpu_be | input | 1 | Core byte order, 1 = big-endian |
| bus_be | input | 1 | Bus byte order, 1 = big-endian |
| mem_rdata | input | 32 | Raw word from memory |
| reg_wdata | input | 32 | Register data to store |
| load_result | output | 32 | Aligned, extended load value |
| mem_wdata | output | 32 | Lane-positioned store data |
| byte_en | output | 4 | Store byte strobes |
| misalign | output | 1 | Misaligned-access flag |

## Verification
On every cycle, the assertions check the following:
- the shape of the strobes;
- that strobes and write data stay quiet on loads;
- that a misaligned access leaves all data outputs zero;
- that sub-word extension fills the upper bits correctly.

Only the bench scenarios can show the remaining behaviour:
- the lane each address actually selects under each core order;
- the lane reversal when the two order bits disagree;
- the store-then-load round trips, and the property that byte positions do not depend on cpu_be;
- the one-cycle output latency.

// File: rtl/ble_pkg.sv
package ble_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;
endpackage

// File: rtl/ble_lane_swap.sv
module ble_lane_swap #(
    parameter int LANE_W = 8,
    parameter int NLANES = 4
) (
    input  logic                     flip,
    input  logic [LANE_W*NLANES-1:0] din,
    output logic [LANE_W*NLANES-1:0] dout
);
    localparam int W = LANE_W * NLANES;

    logic [W-1:0] rev;

    // Lane i of the reversed word takes lane NLANES-1-i of the input.
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        assign rev[i*LANE_W +: LANE_W] = din[(NLANES-1-i)*LANE_W +: LANE_W];
    end

    assign dout = flip ? rev : din;
endmodule

// File: rtl/ble_load_extract.sv
module ble_load_extract
    import ble_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int NLANES = 4
) (
    input  logic [LANE_W*NLANES-1:0]  din,
    input  logic [$clog2(NLANES)-1:0] lane,
    input  acc_size_e                 sz,
    input  logic                      sext,
    output logic [LANE_W*NLANES-1:0]  dout
);
    localparam int W  = LANE_W * NLANES;
    localparam int AW = $clog2(NLANES);
    localparam int HW = 2 * LANE_W;

    logic [LANE_W-1:0] byte_v;
    logic [HW-1:0]     half_v;
    logic [AW-2:0]     hsel;

    assign hsel = lane[AW-1:1];

    always_comb begin
        byte_v = din[lane*LANE_W +: LANE_W];
        half_v = din[hsel*HW +: HW];
        unique case (sz)
            SZ_BYTE: dout = {{(W-LANE_W){sext & byte_v[LANE_W-1]}}, byte_v};
            SZ_HALF: dout = {{(W-HW){sext & half_v[HW-1]}}, half_v};
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/ble_store_place.sv
module ble_store_place
    import ble_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int NLANES = 4
) (
    input  logic [LANE_W*NLANES-1:0]  src,
    input  logic [$clog2(NLANES)-1:0] lane,
    input  acc_size_e                 sz,
    output logic [LANE_W*NLANES-1:0]  dout,
    output logic [NLANES-1:0]         strb
);
    localparam int AW = $clog2(NLANES);
    localparam int HW = 2 * LANE_W;
    localparam logic [NLANES-1:0] S_ONE  = {{(NLANES-1){1'b0}}, 1'b1};
    localparam logic [NLANES-1:0] S_PAIR = {{(NLANES-2){1'b0}}, 2'b11};

    logic [AW-2:0] hsel;

    assign hsel = lane[AW-1:1];

    always_comb begin
        unique case (sz)
            SZ_BYTE: begin
                dout = {NLANES{src[LANE_W-1:0]}};
                strb = S_ONE << lane;
            end
            SZ_HALF: begin
                dout = {(NLANES/2){src[HW-1:0]}};
                strb = S_PAIR << {hsel, 1'b0};
            end
            default: begin
                dout = src;
                strb = '1;
            end
        endcase
    end
endmodule

// File: rtl/ble_lane_aligner.sv
module ble_lane_aligner
    import ble_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int NLANES  = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(NLANES)-1:0] addr,
    input  logic [1:0]                size,
    input  logic                      is_signed,
    input  logic                      is_store,
    input  logic                      cpu_be,
    input  logic                      bus_be,
    input  logic [LANE_W*NLANES-1:0]  mem_rdata,
    input  logic [LANE_W*NLANES-1:0]  reg_wdata,
    output logic [LANE_W*NLANES-1:0]  load_result,
    output logic [LANE_W*NLANES-1:0]  mem_wdata,
    output logic [NLANES-1:0]         byte_en,
    output logic                      misalign
);
    localparam int W  = LANE_W * NLANES;
    localparam int AW = $clog2(NLANES);
    localparam logic [AW-1:0] K_BYTE = AW'(NLANES - 1);
    localparam logic [AW-1:0] K_HALF = AW'(NLANES - 2);

    acc_size_e         sz;
    logic              flip;
    logic [AW-1:0]     lane;
    logic              mis_c;
    logic [W-1:0]      rd_sw, ext_v, wr_pos, wr_sw, res_c, wd_c;
    logic [NLANES-1:0] st_pos, st_sw, be_c;

    assign sz   = acc_size_e'(size);
    assign flip = cpu_be ^ bus_be;

    // Sub-word address remap by core byte order; words pass untouched.
    always_comb begin
        unique case (sz)
            SZ_BYTE: begin
                lane  = addr ^ (cpu_be ? K_BYTE : '0);
                mis_c = 1'b0;
            end
            SZ_HALF: begin
                lane  = addr ^ (cpu_be ? K_HALF : '0);
                mis_c = addr[0];
            end
            default: begin
                lane  = addr;
                mis_c = |addr;
            end
        endcase
    end

    // Load path: lane reversal before extraction.
    ble_lane_swap #(.LANE_W(LANE_W), .NLANES(NLANES)) u_rd_swap (
        .flip (flip),
        .din  (mem_rdata),
        .dout (rd_sw)
    );

    ble_load_extract #(.LANE_W(LANE_W), .NLANES(NLANES)) u_extract (
        .din  (rd_sw),
        .lane (lane),
        .sz   (sz),
        .sext (is_signed),
        .dout (ext_v)
    );

    // Store path: positioning first, lane reversal after.
    ble_store_place #(.LANE_W(LANE_W), .NLANES(NLANES)) u_place (
        .src  (reg_wdata),
        .lane (lane),
        .sz   (sz),
        .dout (wr_pos),
        .strb (st_pos)
    );

    ble_lane_swap #(.LANE_W(LANE_W), .NLANES(NLANES)) u_wr_swap (
        .flip (flip),
        .din  (wr_pos),
        .dout (wr_sw)
    );

    ble_lane_swap #(.LANE_W(1), .NLANES(NLANES)) u_be_swap (
        .flip (flip),
        .din  (st_pos),
        .dout (st_sw)
    );

    always_comb begin
        res_c = (is_store || mis_c) ? '0 : ext_v;
        wd_c  = (is_store && !mis_c) ? wr_sw : '0;
        be_c  = (is_store && !mis_c) ? st_sw : '0;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                load_result <= '0;
                mem_wdata   <= '0;
                byte_en     <= '0;
                misalign    <= 1'b0;
            end else begin
                load_result <= res_c;
                mem_wdata   <= wd_c;
                byte_en     <= be_c;
                misalign    <= mis_c;
            end
        end
    end else begin : g_comb
        assign load_result = res_c;
        assign mem_wdata   = wd_c;
        assign byte_en     = be_c;
        assign misalign    = mis_c;
    end
endmodule

// File: rtl/ble_lane_aligner_chk.sv
module ble_lane_aligner_chk #(
    parameter int LANE_W  = 8,
    parameter int NLANES  = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               size,
    input logic                     is_signed,
    input logic                     is_store,
    input logic [LANE_W*NLANES-1:0] load_result,
    input logic [LANE_W*NLANES-1:0] mem_wdata,
    input logic [NLANES-1:0]        byte_en,
    input logic                     misalign
);
    localparam int W = LANE_W * NLANES;

    logic       seen;
    logic       d_store, d_signed;
    logic [1:0] d_size;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // Align the access attributes with the cycle in which outputs show them.
    if (REG_OUT) begin : g_dly
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_store  <= 1'b0;
                d_signed <= 1'b0;
                d_size   <= 2'b00;
            end else begin
                d_store  <= is_store;
                d_signed <= is_signed;
                d_size   <= size;
            end
        end
    end else begin : g_now
        assign d_store  = is_store;
        assign d_signed = is_signed;
        assign d_size   = size;
    end

    p_load_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !d_store |-> (byte_en == '0) && (mem_wdata == '0));

    p_strobe_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seen && d_store && !misalign |->
            ((d_size == 2'b00) ? ($countones(byte_en) == 1) :
             (d_size == 2'b01) ? (($countones(byte_en) == 2) &&
                                  ((byte_en & (byte_en >> 1)) != '0)) :
                                 (byte_en == '1)));

    p_misalign_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (byte_en == '0) && (mem_wdata == '0) && (load_result == '0));

    p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !d_store && !d_signed && (d_size == 2'b00) |->
            (load_result[W-1:LANE_W] == '0));

    p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !d_store && d_signed && (d_size == 2'b00) |->
            (($countones(load_result[W-1:LANE_W-1]) == 0) ||
             ($countones(load_result[W-1:LANE_W-1]) == W - LANE_W + 1)));
endmodule

bind ble_lane_aligner ble_lane_aligner_chk #(
    .LANE_W  (LANE_W),
    .NLANES  (NLANES),
    .REG_OUT (REG_OUT)
) u_chk (.*);

// File: tb/ble_lane_aligner_test.sv
module ble_lane_aligner_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  addr, size;
    logic        is_signed, is_store, cpu_be, bus_be;
    logic [31:0] mem_rdata, reg_wdata;
    logic [31:0] load_result, mem_wdata;
    logic [3:0]  byte_en;
    logic        misalign;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ble_lane_aligner uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .size(size),
        .is_signed(is_signed), .is_store(is_store), .cpu_be(cpu_be),
        .bus_be(bus_be), .mem_rdata(mem_rdata), .reg_wdata(reg_wdata),
        .load_result(load_result), .mem_wdata(mem_wdata),
        .byte_en(byte_en), .misalign(misalign)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] rev4(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic logic [3:0] rev_be(input logic [3:0] x);
        return {x[0], x[1], x[2], x[3]};
    endfunction

    function automatic bit is_mis(input logic [1:0] a, input logic [1:0] s);
        if (s == 2'd1) return a[0];
        if (s >= 2'd2) return a != 2'd0;
        return 1'b0;
    endfunction

    function automatic int sel_lane(input logic [1:0] a, input logic [1:0] s, input logic c);
        if (s == 2'd0) return c ? 3 - int'(a) : int'(a);
        if (s == 2'd1) return c ? 2 - int'(a) : int'(a);
        return 0;
    endfunction

    function automatic logic [31:0] exp_load(input logic [31:0] d, input logic [1:0] a,
        input logic [1:0] s, input logic sg, input logic c, input logic b);
        logic [31:0] m, v;
        int ln;
        if (is_mis(a, s)) return 32'h0;
        m  = (c != b) ? rev4(d) : d;
        ln = sel_lane(a, s, c);
        if (s == 2'd0) begin
            v = (m >> (8*ln)) & 32'hff;
            if (sg && v[7]) v = v | 32'hffff_ff00;
        end else if (s == 2'd1) begin
            v = (m >> (8*ln)) & 32'hffff;
            if (sg && v[15]) v = v | 32'hffff_0000;
        end else begin
            v = m;
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [31:0] r, input logic [1:0] a,
        input logic [1:0] s, input logic c, input logic b);
        logic [31:0] p;
        if (is_mis(a, s)) return 32'h0;
        if (s == 2'd0)      p = {4{r[7:0]}};
        else if (s == 2'd1) p = {2{r[15:0]}};
        else                p = r;
        return (c != b) ? rev4(p) : p;
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] a, input logic [1:0] s,
        input logic c, input logic b);
        logic [3:0] p;
        if (is_mis(a, s)) return 4'h0;
        if (s == 2'd0)      p = 4'b0001 << sel_lane(a, s, c);
        else if (s == 2'd1) p = 4'b0011 << sel_lane(a, s, c);
        else                p = 4'b1111;
        return (c != b) ? rev_be(p) : p;
    endfunction

    // Drive at a falling edge; result is registered on the next rising edge
    // and sampled at the following falling edge.
    task automatic apply(input logic [1:0] a, input logic [1:0] s, input logic sg,
        input logic st, input logic c, input logic b, input logic [31:0] rd,
        input logic [31:0] wd);
        addr = a; size = s; is_signed = sg; is_store = st;
        cpu_be = c; bus_be = b; mem_rdata = rd; reg_wdata = wd;
        @(negedge clk);
    endtask

    task automatic t_reset;
        apply(2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1234_5678, 32'hdead_beef);
        check("R9 reset load_result", load_result, 32'h0);
        check("R9 reset mem_wdata", mem_wdata, 32'h0);
        check("R9 reset byte_en", {28'h0, byte_en}, 32'h0);
        check("R9 reset misalign", {31'h0, misalign}, 32'h0);
    endtask

    task automatic t_latency;
        apply(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'hcafe_f00d, 32'h0);
        mem_rdata = 32'h0bad_0bad;
        #1;
        check("R9 output held until next edge", load_result, 32'hcafe_f00d);
        @(negedge clk);
        check("R9 output follows after edge", load_result, 32'h0bad_0bad);
    endtask

    task automatic t_loads;
        logic [31:0] pats [3] = '{32'h8192_a3f4, 32'h7f01_6e02, 32'hff80_0180};
        for (int p = 0; p < 3; p++)
            for (int s = 0; s < 4; s++)
                for (int sg = 0; sg < 2; sg++)
                    for (int a = 0; a < 4; a++)
                        for (int m = 0; m < 4; m++) begin
                            apply(2'(a), 2'(s), 1'(sg), 1'b0, m[1], m[0], pats[p], 32'h5555_5555);
                            check("R1 R2 R3 R4 R8 load_result", load_result,
                                  exp_load(pats[p], 2'(a), 2'(s), 1'(sg), m[1], m[0]));
                            check("R6 R7 load strobes/misalign",
                                  {mem_wdata[27:0], byte_en}, 32'h0);
                            check("R7 load misalign", {31'h0, misalign},
                                  {31'h0, is_mis(2'(a), 2'(s))});
                        end
    endtask

    task automatic t_stores;
        logic [31:0] pats [2] = '{32'h1122_3344, 32'h89ab_cdef};
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 4; a++)
                    for (int m = 0; m < 4; m++) begin
                        apply(2'(a), 2'(s), 1'b1, 1'b1, m[1], m[0], 32'hffff_ffff, pats[p]);
                        check("R4 R5 R7 R8 mem_wdata", mem_wdata,
                              exp_wdata(pats[p], 2'(a), 2'(s), m[1], m[0]));
                        check("R4 R5 R7 byte_en", {28'h0, byte_en},
                              {28'h0, exp_be(2'(a), 2'(s), m[1], m[0])});
                        check("R6 store load_result", load_result, 32'h0);
                    end
    endtask

    task automatic t_round_trip;
        logic [31:0] mem;
        logic [3:0]  be_a;
        for (int m = 0; m < 4; m++) begin
            // Word: load under the opposite pair with the same disagreement.
            apply(2'd0, 2'd2, 1'b0, 1'b1, m[1], m[0], 32'h0, 32'ha1b2_c3d4);
            mem = mem_wdata;
            apply(2'd0, 2'd2, 1'b0, 1'b0, !m[1], !m[0], mem, 32'h0);
            check("R10 word round trip", load_result, 32'ha1b2_c3d4);
        end
        for (int b = 0; b < 2; b++) begin
            mem = 32'h0;
            for (int a = 0; a < 4; a++) begin
                apply(2'(a), 2'd0, 1'b0, 1'b1, 1'b0, 1'(b), 32'h0, 32'(8'ha0 + a));
                be_a = byte_en;
                for (int k = 0; k < 4; k++)
                    if (byte_en[k]) mem[8*k +: 8] = mem_wdata[8*k +: 8];
                apply(2'(a), 2'd0, 1'b0, 1'b1, 1'b1, 1'(b), 32'h0, 32'(8'ha0 + a));
                check("R10 byte lane independent of cpu_be", {28'h0, byte_en}, {28'h0, be_a});
            end
            for (int a = 0; a < 4; a++) begin
                apply(2'(a), 2'd0, 1'b0, 1'b0, 1'b1, 1'(b), mem, 32'h0);
                check("R10 byte buffer read under other cpu_be", load_result, 32'(8'ha0 + a));
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        addr = '0; size = '0; is_signed = 1'b0; is_store = 1'b0;
        cpu_be = 1'b0; bus_be = 1'b0; mem_rdata = '0; reg_wdata = '0;
        repeat (2) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_latency;
        t_loads;
        t_stores;
        t_round_trip;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule